// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block turns single-word requests from a synchronous requester into correctly timed read and write cycles on an external asynchronous static RAM of 524,288 bytes. It drives a 19-bit address bus, active-low chip-select, output-enable and write-strobe pins, and an 8-bit data bus that is split into an outgoing value, an incoming value and a drive enable. The pad logic outside the block merges these three into the bidirectional pins.

The requester presents a request together with a direction bit, an address and write data. The request is taken in the one cycle where it meets ready. Read results come back with a single-cycle valid pulse. Each timing phase lasts a whole number of clock cycles. That number is the matching nanosecond figure (given in picoseconds) divided by the clock period and rounded up, and it is never less than one. Writes are strobe-controlled: output-enable stays high for the whole write. The data bus is released, with a turnaround gap, after every read and before the next request can be taken. All memory-side outputs come straight from flip-flops.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and whenever no cycle is in progress, ready is high, chip-select, output-enable and write-strobe are all high, and the data drive enable is low. Ready is low during every phase of a read or write.
- R2: A write runs through three phases with the address held stable. First a setup phase with chip-select low and the strobe high. Then a pulse phase with the strobe low. Then a recovery phase with the strobe high and chip-select still low. After that, chip-select returns high.
- R3: Output-enable stays high during every cycle of a write.
- R4: The data bus is driven with the accepted write byte in every cycle where the strobe is low and in the one cycle right after the strobe rises. It is not driven in any other cycle.
- R5: A read holds chip-select and output-enable low, with the strobe high, for the access phase. The input byte is sampled at the clock edge that ends the access phase. Valid is high for exactly one cycle, which is the cycle right after the access phase.
- R6: After a read, the block spends a turnaround phase with chip-select and output-enable high and the bus undriven, and only then raises ready. The bus is never driven in a cycle right after one with output-enable low.
- R7: Phase lengths with the default 4000 ps clock are: setup 1 cycle (0 ps); pulse 2 cycles, the larger of strobe width 7000 ps and data setup 6000 ps; recovery 1 cycle, stretched if needed so the whole write lasts at least the 10000 ps write cycle; access 3 cycles, the largest of 10000 ps address access, 5000 ps enable access and 10000 ps read cycle; turnaround 2 cycles (5000 ps).
- R8: A request is taken only when request and ready are both high. Address and write data are captured at that edge, so changing them later has no effect on the cycle in progress.
- R9: A byte written to any 19-bit address, including 0 and 0x7FFFF, is returned by a later read of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request a transfer |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 19 | Word address |
| wdata_i | input | 8 | Write byte |
| ready_o | output | 1 | Idle and able to take a request |
| rdata_o | output | 8 | Read byte |
| rvalid_o | output | 1 | One-cycle pulse marking rdata_o |
| sram_addr_o | output | 19 | Memory address pins |
| sram_ce_no | output | 1 | Memory chip-select, active low |
| sram_oe_no | output | 1 | Memory output-enable, active low |
| sram_we_no | output | 1 | Memory write-strobe, active low |
| sram_dq_o | output | 8 | Byte to drive onto the data pins |
| sram_dq_i | input | 8 | Byte seen on the data pins |
| sram_dq_oe_o | output | 1 | Drive enable for the data pins |

## Verification
The assertions take for granted that the external memory puts valid data on its pins within the access phase and takes its own pins off the bus within the turnaround phase. They do not judge whether the read data is correct; they check only pin ordering. In the stimulus, the memory model answers 9 ns after a control or address change, which lands inside the 12 ns access window and frees the bus before the next write can drive it. The model also flags any overlap with the controller's drive. The requester raises a request only while ready is high, drops it after one edge, and then scrambles address and data on purpose, to show that those changes are ignored.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_W_SETUP  = 3'd1,
      ST_W_PULSE  = 3'd2,
      ST_W_RECOV  = 3'd3,
      ST_R_ACCESS = 3'd4,
      ST_R_TURN   = 3'd5
   } sram_state_e;

   // ceiling of a picosecond figure over the clock period, never below one
   function automatic int ps_to_cycles(input int ps, input int period_ps);
      int c;
      c = (ps + period_ps - 1) / period_ps;
      if (c < 1) c = 1;
      return c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
   import sram_ctrl_pkg::*;
#(
   parameter int N_SETUP  = 1,
   parameter int N_PULSE  = 2,
   parameter int N_RECOV  = 1,
   parameter int N_ACCESS = 3,
   parameter int N_TURN   = 2
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        req_i,
   input  logic        wr_i,
   output logic        accept_o,
   output logic        last_o,
   output sram_state_e state_o,
   output sram_state_e nxt_o
);

   localparam int MAX_N = imax(imax(imax(N_SETUP, N_PULSE), imax(N_RECOV, N_ACCESS)), N_TURN);
   localparam int CNT_W = $clog2(MAX_N + 1);

   localparam logic [CNT_W-1:0] L_SETUP  = CNT_W'(N_SETUP - 1);
   localparam logic [CNT_W-1:0] L_PULSE  = CNT_W'(N_PULSE - 1);
   localparam logic [CNT_W-1:0] L_RECOV  = CNT_W'(N_RECOV - 1);
   localparam logic [CNT_W-1:0] L_ACCESS = CNT_W'(N_ACCESS - 1);
   localparam logic [CNT_W-1:0] L_TURN   = CNT_W'(N_TURN - 1);

   sram_state_e      state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d, load_val;
   logic             last;

   assign last = (cnt_q == '0);

   always_comb begin
      state_d  = state_q;
      accept_o = 1'b0;
      unique case (state_q)
         ST_IDLE: if (req_i) begin
            accept_o = 1'b1;
            state_d  = wr_i ? ST_W_SETUP : ST_R_ACCESS;
         end
         ST_W_SETUP:  if (last) state_d = ST_W_PULSE;
         ST_W_PULSE:  if (last) state_d = ST_W_RECOV;
         ST_W_RECOV:  if (last) state_d = ST_IDLE;
         ST_R_ACCESS: if (last) state_d = ST_R_TURN;
         ST_R_TURN:   if (last) state_d = ST_IDLE;
         default:     state_d = ST_IDLE;
      endcase
   end

   always_comb begin
      unique case (state_d)
         ST_W_SETUP:  load_val = L_SETUP;
         ST_W_PULSE:  load_val = L_PULSE;
         ST_W_RECOV:  load_val = L_RECOV;
         ST_R_ACCESS: load_val = L_ACCESS;
         ST_R_TURN:   load_val = L_TURN;
         default:     load_val = '0;
      endcase
      if (state_d != state_q) cnt_d = load_val;
      else                    cnt_d = last ? '0 : cnt_q - 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign last_o  = last;
   assign state_o = state_q;
   assign nxt_o   = state_d;

   // R7: the phase counter never exceeds the longest configured phase
   a_r7_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= CNT_W'(MAX_N - 1));

endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W = 19,
   parameter int DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  sram_state_e       state_i,
   input  sram_state_e       nxt_i,
   input  logic              accept_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [ADDR_W-1:0] sram_addr_o,
   output logic              sram_ce_no,
   output logic              sram_oe_no,
   output logic              sram_we_no,
   output logic [DATA_W-1:0] sram_dq_o,
   output logic              sram_dq_oe_o
);

   logic sel_d, we_d, oe_d, drv_d;

   assign sel_d = (nxt_i == ST_W_SETUP) || (nxt_i == ST_W_PULSE) ||
                  (nxt_i == ST_W_RECOV) || (nxt_i == ST_R_ACCESS);
   assign we_d  = (nxt_i == ST_W_PULSE);
   assign oe_d  = (nxt_i == ST_R_ACCESS);
   // drive while the strobe is low and for the first recovery cycle
   assign drv_d = (nxt_i == ST_W_PULSE) ||
                  ((state_i == ST_W_PULSE) && (nxt_i == ST_W_RECOV));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sram_addr_o  <= '0;
         sram_dq_o    <= '0;
         sram_ce_no   <= 1'b1;
         sram_we_no   <= 1'b1;
         sram_oe_no   <= 1'b1;
         sram_dq_oe_o <= 1'b0;
      end else begin
         if (accept_i) begin
            sram_addr_o <= addr_i;
            sram_dq_o   <= wdata_i;
         end
         sram_ce_no   <= !sel_d;
         sram_we_no   <= !we_d;
         sram_oe_no   <= !oe_d;
         sram_dq_oe_o <= drv_d;
      end
   end

   // R4: the bus is only driven while the chip is selected
   a_r4_drive_needs_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sram_dq_oe_o |-> !sram_ce_no);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
   parameter int DATA_W      = 8,
   parameter bit HOLD_RDATA  = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sample_i,
   input  logic [DATA_W-1:0] dq_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              rvalid_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rvalid_o <= 1'b0;
      else         rvalid_o <= sample_i;
   end

   generate
      if (HOLD_RDATA) begin : g_hold
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)       rdata_o <= '0;
            else if (sample_i) rdata_o <= dq_i;
         end
      end else begin : g_mask
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) rdata_o <= '0;
            else         rdata_o <= sample_i ? dq_i : '0;
         end
      end
   endgenerate

   // R5: valid lasts a single cycle
   a_r5_rvalid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rvalid_o |=> !rvalid_o);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W          = 19,
   parameter int DATA_W          = 8,
   parameter int CLK_PERIOD_PS   = 4000,
   parameter int T_ADDR_SETUP_PS = 0,
   parameter int T_WE_PULSE_PS   = 7000,
   parameter int T_DATA_SETUP_PS = 6000,
   parameter int T_WR_RECOV_PS   = 0,
   parameter int T_WR_CYCLE_PS   = 10000,
   parameter int T_ADDR_ACC_PS   = 10000,
   parameter int T_OE_ACC_PS     = 5000,
   parameter int T_RD_CYCLE_PS   = 10000,
   parameter int T_TURN_PS       = 5000,
   parameter bit HOLD_RDATA      = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              req_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              ready_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              rvalid_o,
   output logic [ADDR_W-1:0] sram_addr_o,
   output logic              sram_ce_no,
   output logic              sram_oe_no,
   output logic              sram_we_no,
   output logic [DATA_W-1:0] sram_dq_o,
   input  logic [DATA_W-1:0] sram_dq_i,
   output logic              sram_dq_oe_o
);

   localparam int N_SETUP  = ps_to_cycles(T_ADDR_SETUP_PS, CLK_PERIOD_PS);
   localparam int N_PULSE  = imax(ps_to_cycles(T_WE_PULSE_PS, CLK_PERIOD_PS),
                                  ps_to_cycles(T_DATA_SETUP_PS, CLK_PERIOD_PS));
   localparam int N_WCYC   = ps_to_cycles(T_WR_CYCLE_PS, CLK_PERIOD_PS);
   localparam int N_RECOV  = imax(ps_to_cycles(T_WR_RECOV_PS, CLK_PERIOD_PS),
                                  N_WCYC - N_SETUP - N_PULSE);
   localparam int N_ACCESS = imax(imax(ps_to_cycles(T_ADDR_ACC_PS, CLK_PERIOD_PS),
                                       ps_to_cycles(T_OE_ACC_PS, CLK_PERIOD_PS)),
                                  ps_to_cycles(T_RD_CYCLE_PS, CLK_PERIOD_PS));
   localparam int N_TURN   = ps_to_cycles(T_TURN_PS, CLK_PERIOD_PS);

   initial begin
      assert (ADDR_W >= 1) else $error("ADDR_W must be positive");
      assert (DATA_W >= 1) else $error("DATA_W must be positive");
      assert (CLK_PERIOD_PS >= 1) else $error("CLK_PERIOD_PS must be positive");
      assert (T_ADDR_SETUP_PS >= 0 && T_WR_RECOV_PS >= 0) else $error("negative timing");
   end

   sram_state_e state, nxt;
   logic        accept, last;

   sram_seq_fsm #(
      .N_SETUP (N_SETUP),
      .N_PULSE (N_PULSE),
      .N_RECOV (N_RECOV),
      .N_ACCESS(N_ACCESS),
      .N_TURN  (N_TURN)
   ) i_fsm (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (req_i),
      .wr_i    (wr_i),
      .accept_o(accept),
      .last_o  (last),
      .state_o (state),
      .nxt_o   (nxt)
   );

   sram_pin_drive #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) i_pins (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .state_i     (state),
      .nxt_i       (nxt),
      .accept_i    (accept),
      .addr_i      (addr_i),
      .wdata_i     (wdata_i),
      .sram_addr_o (sram_addr_o),
      .sram_ce_no  (sram_ce_no),
      .sram_oe_no  (sram_oe_no),
      .sram_we_no  (sram_we_no),
      .sram_dq_o   (sram_dq_o),
      .sram_dq_oe_o(sram_dq_oe_o)
   );

   sram_rd_capture #(
      .DATA_W    (DATA_W),
      .HOLD_RDATA(HOLD_RDATA)
   ) i_cap (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sample_i((state == ST_R_ACCESS) && last),
      .dq_i    (sram_dq_i),
      .rdata_o (rdata_o),
      .rvalid_o(rvalid_o)
   );

   assign ready_o = (state == ST_IDLE);

   // R1: idle means every control pin is inactive and the bus is released
   a_r1_idle_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ready_o |-> (sram_ce_no && sram_we_no && sram_oe_no && !sram_dq_oe_o));

   // R2: the address pins do not move while the chip is selected
   a_r2_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sram_ce_no |=> (sram_ce_no || $stable(sram_addr_o)));

   // R3: output-enable stays high while the strobe is low
   a_r3_oe_high_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sram_we_no |-> sram_oe_no);

   // R4: write data is on the bus throughout the strobe pulse
   a_r4_drive_during_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sram_we_no |-> sram_dq_oe_o);

   // R4: data is still driven in the cycle where the strobe rises
   a_r4_hold_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sram_we_no) |-> sram_dq_oe_o);

   // R5: a valid pulse only follows a cycle with output-enable low
   a_r5_valid_after_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rvalid_o |-> $past(!sram_oe_no));

   // R6: no drive in the cycle right after output-enable was low
   a_r6_turnaround: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sram_oe_no |=> !sram_dq_oe_o);

endmodule

// File: tb/test_sram_async_ctrl.sv
`timescale 1ns/1ps
module test_sram_async_ctrl;

   localparam int PER_PS = 4000;

   // expected phase lengths from the requirement figures
   function automatic int up(input int ps);
      int c;
      c = ps / PER_PS;
      if (c * PER_PS < ps) c = c + 1;
      if (c == 0) c = 1;
      return c;
   endfunction

   int exp_setup, exp_pulse, exp_recov, exp_acc, exp_turn;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic        wr = 1'b0;
   logic [18:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic        ready, rvalid;
   logic [7:0]  rdata;
   logic [18:0] s_addr;
   logic        s_ce_n, s_oe_n, s_we_n, s_dq_oe;
   logic [7:0]  s_dq_o;
   logic [7:0]  m_val;
   logic        m_drv;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   sram_async_ctrl i_sram_async_ctrl (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .req_i       (req),
      .wr_i        (wr),
      .addr_i      (addr),
      .wdata_i     (wdata),
      .ready_o     (ready),
      .rdata_o     (rdata),
      .rvalid_o    (rvalid),
      .sram_addr_o (s_addr),
      .sram_ce_no  (s_ce_n),
      .sram_oe_no  (s_oe_n),
      .sram_we_no  (s_we_n),
      .sram_dq_o   (s_dq_o),
      .sram_dq_i   (m_val),
      .sram_dq_oe_o(s_dq_oe)
   );

   task automatic check(input bit ok, input string rq, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   // ---------------- behavioural memory model ----------------
   logic [7:0] mem [int];
   logic [7:0] shadow [int];
   int         mem_upd = 0;
   logic       rd_mode;
   logic [7:0] rd_now;
   realtime    t_we_fall = 0.0;
   realtime    t_data = 0.0;
   bit         run = 1'b0;

   always @(s_addr or s_ce_n or s_we_n or s_oe_n or mem_upd) begin
      rd_mode = (s_ce_n === 1'b0) && (s_we_n === 1'b1) && (s_oe_n === 1'b0);
      if (rd_mode && mem.exists(int'(s_addr))) rd_now = mem[int'(s_addr)];
      else if (rd_mode)                        rd_now = 8'hEE;
      else                                     rd_now = 8'h00;
   end

   assign #9 m_drv = rd_mode;
   assign #9 m_val = rd_now;

   always @(negedge s_we_n) if (run) t_we_fall = $realtime;
   always @(posedge s_dq_oe or s_dq_o) if (run) t_data = $realtime;

   always @(posedge s_we_n) begin
      if (run && s_ce_n === 1'b0) begin
         check(($realtime - t_we_fall) >= 7.0, "R7", "strobe width ps",
               int'(($realtime - t_we_fall) * 1000), 7000);
         check(($realtime - t_data) >= 6.0, "R7", "data setup ps",
               int'(($realtime - t_data) * 1000), 6000);
         check(s_dq_oe === 1'b1, "R4", "drive at strobe rise", int'(s_dq_oe), 1);
         mem[int'(s_addr)] = s_dq_o;
         mem_upd++;
      end
   end

   // R6: controller and memory never drive the bus together
   always @(negedge clk) begin
      if (run && s_dq_oe && m_drv) begin
         n_chk++;
         n_fail++;
         $display("FAIL R6 bus contention: actual %0d expected %0d", 1, 0);
      end
   end

   // ---------------- scenario tasks ----------------
   task automatic tc_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(s_ce_n && s_we_n && s_oe_n && !s_dq_oe && !rvalid, "R1", "pins in reset",
            {s_ce_n, s_we_n, s_oe_n, s_dq_oe, rvalid}, 5'b11100);
      rst_n = 1'b1;
      run = 1'b1;
      @(negedge clk);
      check(ready === 1'b1, "R1", "ready after reset", int'(ready), 1);
   endtask

   task automatic tc_idle;
      bit bad;
      bad = 1'b0;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         if (!(ready && s_ce_n && s_we_n && s_oe_n && !s_dq_oe)) bad = 1'b1;
      end
      check(!bad, "R1", "idle deselect", int'(bad), 0);
   endtask

   task automatic tc_write(input logic [18:0] a, input logic [7:0] d, input bit scramble);
      int  s, p, r;
      bit  oe_bad, drv_bad, addr_bad, rdy_bad;
      s = 0; p = 0; r = 0;
      oe_bad = 0; drv_bad = 0; addr_bad = 0; rdy_bad = 0;
      @(negedge clk);
      while (!ready) @(negedge clk);
      req = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      #1;
      req = 1'b0;
      if (scramble) begin addr = ~a; wdata = ~d; end
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         if (s_ce_n) break;
         if (ready) rdy_bad = 1;
         if (!s_oe_n) oe_bad = 1;
         if (s_addr !== a) addr_bad = 1;
         if (!s_we_n) begin
            p++;
            if (!s_dq_oe || s_dq_o !== d) drv_bad = 1;
         end else if (p == 0) begin
            s++;
            if (s_dq_oe) drv_bad = 1;
         end else begin
            r++;
            if (r == 1 && (!s_dq_oe || s_dq_o !== d)) drv_bad = 1;
            if (r > 1 && s_dq_oe) drv_bad = 1;
         end
      end
      check(s == exp_setup, "R2", "setup cycles", s, exp_setup);
      check(p == exp_pulse, "R7", "pulse cycles", p, exp_pulse);
      check(r == exp_recov, "R7", "recovery cycles", r, exp_recov);
      check(!oe_bad, "R3", "oe low during write", int'(oe_bad), 0);
      check(!drv_bad, "R4", "data drive window", int'(drv_bad), 0);
      check(!addr_bad, "R8", "captured address held", int'(addr_bad), 0);
      check(!rdy_bad, "R1", "ready low while busy", int'(rdy_bad), 0);
      check(ready && !s_dq_oe, "R1", "idle after write", {ready, s_dq_oe}, 2'b10);
      shadow[int'(a)] = d;
   endtask

   task automatic tc_read(input logic [18:0] a, input logic [7:0] e);
      int  acc, rv_cnt, rv_k, turn;
      bit  drv_bad;
      logic [7:0] got;
      acc = 0; rv_cnt = 0; rv_k = -1; turn = 0; drv_bad = 0; got = 8'h00;
      @(negedge clk);
      while (!ready) @(negedge clk);
      req = 1'b1; wr = 1'b0; addr = a; wdata = 8'h00;
      @(posedge clk);
      #1;
      req = 1'b0;
      for (int k = 1; k <= 20; k++) begin
         @(negedge clk);
         if (ready) break;
         if (s_dq_oe || !s_we_n) drv_bad = 1;
         if (!s_ce_n && !s_oe_n) acc++;
         if (s_ce_n && s_oe_n) turn++;
         if (rvalid) begin rv_cnt++; rv_k = k; got = rdata; end
      end
      check(acc == exp_acc, "R5", "access cycles", acc, exp_acc);
      check(rv_cnt == 1, "R5", "valid pulse count", rv_cnt, 1);
      check(rv_k == exp_acc + 1, "R5", "valid cycle", rv_k, exp_acc + 1);
      check(turn == exp_turn, "R6", "turnaround cycles", turn, exp_turn);
      check(!drv_bad, "R6", "no drive or strobe in read", int'(drv_bad), 0);
      check(got === e, "R9", "read data", int'(got), int'(e));
   endtask

   task automatic tc_boundaries;
      tc_write(19'h00000, 8'h3C, 1'b0);
      tc_write(19'h7FFFF, 8'hC3, 1'b0);
      tc_read(19'h00000, 8'h3C);
      tc_read(19'h7FFFF, 8'hC3);
   endtask

   task automatic tc_capture;
      // R8: inputs changed after acceptance must not redirect the write
      tc_write(~19'h02AA0, 8'h5A, 1'b0);
      tc_write(19'h02AA0, 8'h81, 1'b1);
      tc_read(19'h02AA0, 8'h81);
      tc_read(~19'h02AA0, 8'h5A);
   endtask

   task automatic tc_back_to_back;
      // R6: write issued right after a read
      tc_read(19'h00000, 8'h3C);
      tc_write(19'h00001, 8'h99, 1'b0);
      tc_read(19'h00001, 8'h99);
   endtask

   task automatic tc_random;
      logic [18:0] al [16];
      for (int i = 0; i < 16; i++) begin
         al[i] = 19'($urandom);
         tc_write(al[i], 8'($urandom), 1'b0);
      end
      for (int i = 0; i < 16; i++) tc_read(al[i], shadow[int'(al[i])]);
   endtask

   initial begin
      exp_setup = up(0);
      exp_pulse = (up(7000) > up(6000)) ? up(7000) : up(6000);
      exp_recov = up(0);
      if (exp_setup + exp_pulse + exp_recov < up(10000))
         exp_recov = up(10000) - exp_setup - exp_pulse;
      exp_acc  = up(10000);
      if (up(5000) > exp_acc) exp_acc = up(5000);
      exp_turn = up(5000);
      tc_reset();
      tc_idle();
      tc_boundaries();
      tc_capture();
      tc_back_to_back();
      tc_random();
      tc_idle();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #800000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule